// File: doc/BRIEF.md
# PWM Output Steering with Period-Aligned Updates

This block takes one already-generated PWM waveform and distributes it onto four output pins, named A, B, C and D. Each pin is chosen on its own to carry the waveform; a pin that is not chosen drives a per-pin static data value instead. The set of chosen pins is written through a one-cycle write strobe. It takes effect on the next clock edge, or it is held and applied only when the next PWM period begins. The second choice means that a pin never shows a shortened pulse when it is switched on or off.

Two polarity bits invert the waveform. One bit covers pins A and C and the other covers pins B and D. The inversion applies only to pins that carry the waveform. All pins stay tri-stated, with their output enables low, until a driver-enable input is raised. A sticky period flag rises once the second period has begun after the PWM mode was switched on. Firmware can therefore wait for one full cycle before it enables the drivers.

All pins of the block are plain control and status signals. No data stream crosses the block, so there is no valid/ready handshake and no back-pressure. A write strobe is always accepted in the cycle it is high.

Top module: `pwm_steer`

## Requirements
- R1: After reset the active steering set is empty, the period flag is 0, and every pin has its output enable and output value at 0.
- R2: When drv_en is 0, all four pin_oe bits and all four pin_out bits are 0. When drv_en is 1, all four pin_oe bits are 1.
- R3: A steered pin drives pwm_in XOR its polarity bit. pol_sel[0] applies to pins A (bit 0) and C (bit 2), and pol_sel[1] applies to pins B (bit 1) and D (bit 3). A polarity bit of 1 means active-low, that is, inverted.
- R4: A pin that is not steered drives its port_data bit, and polarity has no effect on it.
- R5: When sync_mode is 0, steer_data written by steer_wr becomes the active set at that clock edge and shows on the pins in the following cycle.
- R6: When sync_mode is 1, a write is held pending and the active set does not change until an edge where period_start is 1. The pending set is applied at that edge.
- R7: When sync_mode is 1, a write replaces any pending value that has not yet been applied, so the last write before the boundary is the one applied.
- R8: When sync_mode is 1 and steer_wr and period_start are high in the same cycle, the newly written set is applied at that edge.
- R9: While pwm_run is 1, period_flag becomes 1 at the edge of the second period_start pulse since pwm_run last rose. Lowering pwm_run restarts the count.
- R10: period_flag stays set until flag_clr is 1. If a set condition and flag_clr occur in the same cycle, the flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pwm_in | input | 1 | Raw PWM waveform |
| period_start | input | 1 | One-cycle strobe at the start of each PWM period |
| pwm_run | input | 1 | High while the PWM mode is enabled |
| steer_wr | input | 1 | Write strobe for the steering set |
| steer_data | input | 4 | New steering set, bit i = pin i carries the PWM |
| sync_mode | input | 1 | 0 = apply at once, 1 = apply at the next period start |
| pol_sel | input | 2 | Bit 0: A/C pair inverted; bit 1: B/D pair inverted |
| port_data | input | 4 | Static value for pins that are not steered |
| drv_en | input | 1 | Pin output driver enable |
| flag_clr | input | 1 | Clears the period flag |
| pin_out | output | 4 | Pin values, bit 0 = A to bit 3 = D |
| pin_oe | output | 4 | Per-pin output enables |
| period_flag | output | 1 | Sticky flag: one full period has elapsed |

## Verification
A wrong active steering set shows on pin_out in the cycle right after the faulty edge, but only while drv_en is high and pwm_in differs from port_data on the affected pin. The bench therefore sets those two values to differ before it samples. A pending value that is lost or applied too early in sync mode stays hidden until the next period_start edge, or shows one cycle too soon, so the bench samples both before and after every boundary. A wrong period count in the flag logic shows one strobe early or one strobe late on period_flag.

// File: rtl/pwm_steer_pkg.sv
package pwm_steer_pkg;
  localparam int unsigned PIN_N  = 4;
  localparam int unsigned PAIR_N = 2;

  typedef logic [PIN_N-1:0]  pin_vec_t;
  typedef logic [PAIR_N-1:0] pol_vec_t;

  // pins A..D map to pairs A/C and B/D
  function automatic int unsigned pair_of(input int unsigned pin);
    return pin % PAIR_N;
  endfunction
endpackage

// File: rtl/pwm_steer_sel.sv
module pwm_steer_sel
  import pwm_steer_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     wr,
  input  pin_vec_t wdata,
  input  logic     sync_mode,
  input  logic     period_start,
  output pin_vec_t active
);
  pin_vec_t pend_q;
  logic     pend_v_q;
  pin_vec_t act_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q    <= '0;
      pend_q   <= '0;
      pend_v_q <= 1'b0;
    end else if (wr && !sync_mode) begin
      act_q    <= wdata;
      pend_v_q <= 1'b0;
    end else if (sync_mode && period_start) begin
      if (wr)            act_q <= wdata;
      else if (pend_v_q) act_q <= pend_q;
      pend_v_q <= 1'b0;
    end else if (wr) begin
      pend_q   <= wdata;
      pend_v_q <= 1'b1;
    end
  end

  assign active = act_q;
endmodule

// File: rtl/pwm_period_mon.sv
module pwm_period_mon #(
  parameter int unsigned FLAG_AT = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic period_start,
  input  logic clr,
  output logic flag
);
  localparam int unsigned CW = $clog2(FLAG_AT + 1);
  localparam logic [CW-1:0] SET_AT = CW'(FLAG_AT - 1);
  localparam logic [CW-1:0] SAT    = CW'(FLAG_AT);

  logic [CW-1:0] cnt_q;
  logic          flag_q;
  logic          set_now;

  assign set_now = run && period_start && (cnt_q == SET_AT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!run) begin
      cnt_q <= '0;
    end else if (period_start && (cnt_q != SAT)) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       flag_q <= 1'b0;
    else if (set_now) flag_q <= 1'b1;
    else if (clr)     flag_q <= 1'b0;
  end

  assign flag = flag_q;
endmodule

// File: rtl/pwm_pin_drive.sv
module pwm_pin_drive (
  input  logic steer,
  input  logic pwm,
  input  logic inv,
  input  logic port_bit,
  input  logic en,
  output logic out,
  output logic oe
);
  logic level;

  always_comb begin
    level = steer ? (pwm ^ inv) : port_bit;
    out   = en & level;
    oe    = en;
  end
endmodule

// File: rtl/pwm_steer.sv
module pwm_steer
  import pwm_steer_pkg::*;
#(
  parameter int unsigned FLAG_AT = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwm_in,
  input  logic             period_start,
  input  logic             pwm_run,
  input  logic             steer_wr,
  input  logic [PIN_N-1:0] steer_data,
  input  logic             sync_mode,
  input  logic [PAIR_N-1:0] pol_sel,
  input  logic [PIN_N-1:0] port_data,
  input  logic             drv_en,
  input  logic             flag_clr,
  output logic [PIN_N-1:0] pin_out,
  output logic [PIN_N-1:0] pin_oe,
  output logic             period_flag
);
  pin_vec_t steer_act;

  pwm_steer_sel u_sel (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr           (steer_wr),
    .wdata        (steer_data),
    .sync_mode    (sync_mode),
    .period_start (period_start),
    .active       (steer_act)
  );

  pwm_period_mon #(.FLAG_AT(FLAG_AT)) u_mon (
    .clk          (clk),
    .rst_n        (rst_n),
    .run          (pwm_run),
    .period_start (period_start),
    .clr          (flag_clr),
    .flag         (period_flag)
  );

  for (genvar i = 0; i < PIN_N; i++) begin : g_pin
    localparam int unsigned PR = pair_of(i);
    pwm_pin_drive u_drv (
      .steer    (steer_act[i]),
      .pwm      (pwm_in),
      .inv      (pol_sel[PR]),
      .port_bit (port_data[i]),
      .en       (drv_en),
      .out      (pin_out[i]),
      .oe       (pin_oe[i])
    );
  end
endmodule

// File: rtl/pwm_steer_chk.sv
module pwm_steer_chk
  import pwm_steer_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             pwm_in,
  input logic             period_start,
  input logic             pwm_run,
  input logic             steer_wr,
  input logic [PIN_N-1:0] steer_data,
  input logic             sync_mode,
  input logic [PAIR_N-1:0] pol_sel,
  input logic             drv_en,
  input logic             flag_clr,
  input logic [PIN_N-1:0] pin_out,
  input logic [PIN_N-1:0] pin_oe,
  input logic             period_flag,
  input logic [PIN_N-1:0] steer_act
);
  p_tristate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !drv_en |-> (pin_oe == '0) && (pin_out == '0));

  p_pin_a_pol_r3: assert property (@(posedge clk) disable iff (!rst_n)
    drv_en && steer_act[0] |-> pin_out[0] == (pwm_in ^ pol_sel[0]));

  p_imm_apply_r5: assert property (@(posedge clk) disable iff (!rst_n)
    steer_wr && !sync_mode |=> steer_act == $past(steer_data));

  p_sync_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sync_mode && !period_start |=> $stable(steer_act));

  p_flag_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(period_flag) |-> $past(period_start && pwm_run));

  p_flag_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    period_flag && !flag_clr |=> period_flag);

  p_flag_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    period_flag && flag_clr && !period_start |=> !period_flag);
endmodule

bind pwm_steer pwm_steer_chk chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .pwm_in       (pwm_in),
  .period_start (period_start),
  .pwm_run      (pwm_run),
  .steer_wr     (steer_wr),
  .steer_data   (steer_data),
  .sync_mode    (sync_mode),
  .pol_sel      (pol_sel),
  .drv_en       (drv_en),
  .flag_clr     (flag_clr),
  .pin_out      (pin_out),
  .pin_oe       (pin_oe),
  .period_flag  (period_flag),
  .steer_act    (steer_act)
);

// File: tb/pwm_steer_tb.sv
module pwm_steer_tb_top;
  localparam int CLK_P = 10;
  localparam int NVEC  = 6;
  // {steer[3:0], pol[1:0], port[3:0], pwm, expected[3:0]}
  localparam logic [14:0] VEC [NVEC] = '{
    {4'b0000, 2'b00, 4'b1010, 1'b1, 4'b1010},
    {4'b1111, 2'b00, 4'b0000, 1'b1, 4'b1111},
    {4'b1111, 2'b01, 4'b0000, 1'b1, 4'b1010},
    {4'b0101, 2'b11, 4'b0010, 1'b1, 4'b0010},
    {4'b1001, 2'b10, 4'b0110, 1'b0, 4'b1110},
    {4'b0110, 2'b01, 4'b1001, 1'b1, 4'b1011}
  };

  logic clk = 1'b0;
  logic rst_n, pwm_in, period_start, pwm_run, steer_wr, sync_mode;
  logic drv_en, flag_clr;
  logic [3:0] steer_data, port_data, pin_out, pin_oe;
  logic [1:0] pol_sel;
  logic period_flag;
  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #(CLK_P/2) clk = ~clk;

  pwm_steer dut_i (
    .clk(clk), .rst_n(rst_n), .pwm_in(pwm_in), .period_start(period_start),
    .pwm_run(pwm_run), .steer_wr(steer_wr), .steer_data(steer_data),
    .sync_mode(sync_mode), .pol_sel(pol_sel), .port_data(port_data),
    .drv_en(drv_en), .flag_clr(flag_clr), .pin_out(pin_out),
    .pin_oe(pin_oe), .period_flag(period_flag)
  );

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic wr_steer(input logic [3:0] d);
    steer_wr = 1'b1; steer_data = d;
    tick();
    steer_wr = 1'b0;
  endtask

  task automatic strobe();
    period_start = 1'b1;
    tick();
    period_start = 1'b0;
  endtask

  initial begin
    #(CLK_P * 100000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0; pwm_in = 0; period_start = 0; pwm_run = 0; steer_wr = 0;
    sync_mode = 0; drv_en = 0; flag_clr = 0; steer_data = 0; port_data = 0;
    pol_sel = 0;
    tick(); tick();
    rst_n = 1;
    #1;
    // R1 reset state
    chk("R1 oe", pin_oe, 4'b0000);
    chk("R1 out", pin_out, 4'b0000);
    chk("R1 flag", {3'b0, period_flag}, 4'b0000);
    // R1 active set empty: pins show port data while pwm high
    drv_en = 1; pwm_in = 1; port_data = 4'b0000; #1;
    chk("R1 steer empty", pin_out, 4'b0000);

    // R2 tristate while steered
    wr_steer(4'b1111);
    drv_en = 0; #1;
    chk("R2 oe off", pin_oe, 4'b0000);
    chk("R2 out off", pin_out, 4'b0000);
    drv_en = 1; #1;
    chk("R2 oe on", pin_oe, 4'b1111);

    // R3/R4 vector table, sync mode 0
    for (int k = 0; k < NVEC; k++) begin
      wr_steer(VEC[k][14:11]);
      pol_sel = VEC[k][10:9]; port_data = VEC[k][8:5]; pwm_in = VEC[k][4];
      #1;
      chk($sformatf("R3/R4 vec%0d", k), pin_out, VEC[k][3:0]);
    end

    // R5 immediate apply, visible before/after edge
    pol_sel = 0; port_data = 0; pwm_in = 1;
    wr_steer(4'b0000);
    steer_wr = 1; steer_data = 4'b0011; #1;
    chk("R5 before edge", pin_out, 4'b0000);
    tick(); steer_wr = 0;
    chk("R5 after edge", pin_out, 4'b0011);

    // R6 deferred apply
    sync_mode = 1;
    wr_steer(4'b1100);
    chk("R6 held", pin_out, 4'b0011);
    tick(); tick();
    chk("R6 still held", pin_out, 4'b0011);
    strobe();
    chk("R6 applied", pin_out, 4'b1100);

    // R7 last write wins
    wr_steer(4'b0001);
    wr_steer(4'b1000);
    chk("R7 held", pin_out, 4'b1100);
    strobe();
    chk("R7 last wins", pin_out, 4'b1000);

    // R8 write coincident with boundary
    period_start = 1; steer_wr = 1; steer_data = 4'b0100;
    tick();
    period_start = 0; steer_wr = 0;
    chk("R8 same-cycle", pin_out, 4'b0100);
    sync_mode = 0;

    // R9 flag at second period start
    pwm_run = 1; tick();
    strobe();
    chk("R9 after first", {3'b0, period_flag}, 4'b0000);
    tick();
    strobe();
    chk("R9 after second", {3'b0, period_flag}, 4'b0001);

    // R10 sticky and clear
    tick(); tick();
    chk("R10 sticky", {3'b0, period_flag}, 4'b0001);
    flag_clr = 1; tick(); flag_clr = 0;
    chk("R10 cleared", {3'b0, period_flag}, 4'b0000);
    strobe();
    chk("R9 no reset after saturation", {3'b0, period_flag}, 4'b0000);

    // R9 restart and R10 set beats clear
    pwm_run = 0; tick(); pwm_run = 1; tick();
    strobe();
    chk("R9 restart first", {3'b0, period_flag}, 4'b0000);
    period_start = 1; flag_clr = 1;
    tick();
    period_start = 0; flag_clr = 0;
    chk("R10 set over clear", {3'b0, period_flag}, 4'b0001);

    finished = 1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule